// File: doc/BRIEF.md
# Power-Fail and Low-Power Mode Controller

This block sits beside a microcontroller core. It turns a digital supply-monitor comparator level into a sticky power-fail flag and a maskable interrupt. It also records that a power-up took place. Software sees both flags as status pins and changes them through a small write port. Software can also raise the interrupt itself by writing the power-fail flag to 1.

The same block owns the two low-power modes. Idle stops the CPU clock and keeps the peripheral clock running. Stop removes both clocks. Leaving idle takes a pending enabled interrupt. Leaving stop takes an external wake pulse or a reset. A bandgap-select bit decides whether the reference, and with it power-fail detection and the power-fail interrupt, stays alive while the block is in stop. The comparator level passes through a two-flop synchronizer and an edge detector. Each rise of the comparator sets the flag once.

The write port has two registers, chosen by `ctl_sel`. Register 0 holds the flags: bit 0 is the interrupt enable, bit 1 is the power-fail flag and bit 2 is the power-on flag. Register 1 holds the mode: bit 0 requests idle, bit 1 requests stop and bit 2 is bandgap select. There are two resets. `por_n` is the power-up reset. `rst_n` is a warm reset, and it leaves both flags as they were.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `por_n` is low and after it is released, the power-on flag reads 1. The power-fail flag, interrupt enable, bandgap select, idle and stop read 0, both clock enables and `bg_en_o` read 1, and `pf_irq_o` and `pf_vec_o` read 0.
- R2: A low pulse on `rst_n` alone keeps both flags. It clears the interrupt enable and bandgap select and returns the block to run mode.
- R3: A write to register 0 with bit 2 = 0 clears the power-on flag. Writing bit 2 = 1 leaves it unchanged. Nothing else ever clears it, apart from `por_n`.
- R4: A rise on `pf_cmp_i` sets the power-fail flag on the third rising clock edge after it. A flag that software clears while the comparator stays high stays clear until the comparator falls and rises again.
- R5: The power-fail flag follows bit 1 of each register-0 write, and no hardware event clears it. If a hardware set and a software clear land in the same cycle, the flag ends up set.
- R6: Writing 1 to bit 1 of register 0 sets the power-fail flag with the comparator low.
- R7: `pf_irq_o` is high only while the power-fail flag and the interrupt enable are both 1. While it is high, `pf_vec_o` reads 0x33; otherwise `pf_vec_o` reads 0.
- R8: From run, a register-1 write with bit 1 = 1 enters stop, with both clock enables 0. Otherwise a write with bit 0 = 1 enters idle, with the CPU clock off and the peripheral clock on. Stop wins when both bits are 1.
- R9: In idle, a cycle with `pf_irq_o` or `irq_any_i` high returns the block to run on the next clock edge.
- R10: Stop ends only on a `wake_i` pulse, or on a reset. Interrupts do not end it.
- R11: In stop with bandgap select 0, `bg_en_o` and `pf_irq_o` are 0 and comparator rises are ignored. With bandgap select 1, `bg_en_o` stays 1 and detection works.
- R12: Register-1 writes made while in idle or stop are ignored, and that includes the bandgap-select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| rst_n | input | 1 | Warm reset, active low, asynchronous |
| pf_cmp_i | input | 1 | Supply comparator, 1 = supply below threshold, asynchronous |
| ctl_we | input | 1 | Register write strobe |
| ctl_sel | input | 1 | Register select: 0 flags, 1 mode |
| ctl_wdata | input | 3 | Write data |
| irq_any_i | input | 1 | Another enabled interrupt is pending |
| wake_i | input | 1 | External wake from stop |
| pf_irq_o | output | 1 | Power-fail interrupt request |
| pf_vec_o | output | 8 | Interrupt vector while requesting, else 0 |
| por_flag_o | output | 1 | Power-on flag |
| pf_flag_o | output | 1 | Power-fail flag |
| pf_ien_o | output | 1 | Power-fail interrupt enable |
| bgs_o | output | 1 | Bandgap select |
| idle_o | output | 1 | Idle mode active |
| stop_o | output | 1 | Stop mode active |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| bg_en_o | output | 1 | Bandgap reference enable |

## Verification
The checker watches on every cycle that:
- the flags fall only on the matching software write;
- stop holds until a wake pulse, and stop gates both clocks;
- idle ends one edge after a pending interrupt;
- the bandgap-select bit cannot change outside run mode;
- with the bandgap off, no comparator event can set the flag.

Only the directed scenarios can show some other behaviours:
- the exact three-edge latency of detection;
- the single set for each comparator rise;
- the outcome of a hardware set that meets a software clear in the same cycle;
- the way a warm reset keeps the flags.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int CTL_W = 3;

  // register select
  localparam logic SEL_FLAGS = 1'b0;
  localparam logic SEL_MODE  = 1'b1;

  // register 0 fields
  localparam int F_IEN = 0;
  localparam int F_PFF = 1;
  localparam int F_POF = 2;

  // register 1 fields
  localparam int M_IDLE = 0;
  localparam int M_STOP = 1;
  localparam int M_BGS  = 2;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_STOP = 2'd2
  } pm_state_e;
endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sh;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sh[LAST];
  end

  assign rise_o = sh[LAST] & ~prev;
endmodule

// File: rtl/pwr_flags.sv
module pwr_flags
  import pwr_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             pf_rise,
  input  logic             det_en,
  input  logic             we,
  input  logic             sel,
  input  logic [CTL_W-1:0] wdata,
  output logic             por_flag,
  output logic             pf_flag,
  output logic             pf_ien,
  output logic             irq
);
  logic flag_wr;
  logic hw_set;

  assign flag_wr = we && (sel == SEL_FLAGS);
  assign hw_set  = pf_rise && det_en;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                      por_flag <= 1'b1;
    else if (flag_wr && !wdata[F_POF]) por_flag <= 1'b0;
  end

  // hardware set wins over a same-cycle software write
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       pf_flag <= 1'b0;
    else if (hw_set)  pf_flag <= 1'b1;
    else if (flag_wr) pf_flag <= wdata[F_PFF];
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)   pf_ien <= 1'b0;
    else if (flag_wr) pf_ien <= wdata[F_IEN];
  end

  assign irq = pf_flag && pf_ien && det_en;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_pkg::*;
(
  input  logic             clk,
  input  logic             sys_rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [CTL_W-1:0] wdata,
  input  logic             wake_i,
  input  logic             wake_irq,
  output pm_state_e        state,
  output logic             bgs,
  output logic             det_en
);
  pm_state_e nxt;
  logic      mode_wr;

  assign mode_wr = we && (sel == SEL_MODE) && (state == PM_RUN);

  always_comb begin
    nxt = state;
    unique case (state)
      PM_RUN: begin
        if (mode_wr) begin
          if (wdata[M_STOP])      nxt = PM_STOP;
          else if (wdata[M_IDLE]) nxt = PM_IDLE;
        end
      end
      PM_IDLE: if (wake_irq) nxt = PM_RUN;
      PM_STOP: if (wake_i)   nxt = PM_RUN;
      default: nxt = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) state <= PM_RUN;
    else            state <= nxt;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)   bgs <= 1'b0;
    else if (mode_wr) bgs <= wdata[M_BGS];
  end

  assign det_en = !((state == PM_STOP) && !bgs);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          VEC_W       = 8,
  parameter int unsigned PF_VECTOR   = 'h33
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             pf_cmp_i,
  input  logic             ctl_we,
  input  logic             ctl_sel,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             irq_any_i,
  input  logic             wake_i,
  output logic             pf_irq_o,
  output logic [VEC_W-1:0] pf_vec_o,
  output logic             por_flag_o,
  output logic             pf_flag_o,
  output logic             pf_ien_o,
  output logic             bgs_o,
  output logic             idle_o,
  output logic             stop_o,
  output logic             cpu_clk_en_o,
  output logic             periph_clk_en_o,
  output logic             bg_en_o
);
  logic      sys_rst_n;
  logic      pf_rise;
  logic      det_en;
  pm_state_e state;

  assign sys_rst_n = por_n & rst_n;

  pf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (por_n),
    .async_i (pf_cmp_i),
    .rise_o  (pf_rise)
  );

  pwr_flags u_flags (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .pf_rise   (pf_rise),
    .det_en    (det_en),
    .we        (ctl_we),
    .sel       (ctl_sel),
    .wdata     (ctl_wdata),
    .por_flag  (por_flag_o),
    .pf_flag   (pf_flag_o),
    .pf_ien    (pf_ien_o),
    .irq       (pf_irq_o)
  );

  pwr_mode_fsm u_fsm (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .we        (ctl_we),
    .sel       (ctl_sel),
    .wdata     (ctl_wdata),
    .wake_i    (wake_i),
    .wake_irq  (pf_irq_o | irq_any_i),
    .state     (state),
    .bgs       (bgs_o),
    .det_en    (det_en)
  );

  assign idle_o          = (state == PM_IDLE);
  assign stop_o          = (state == PM_STOP);
  assign cpu_clk_en_o    = (state == PM_RUN);
  assign periph_clk_en_o = (state != PM_STOP);
  assign bg_en_o         = det_en;
  assign pf_vec_o        = pf_irq_o ? VEC_W'(PF_VECTOR) : '0;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk
  import pwr_pkg::*;
#(
  parameter int          VEC_W     = 8,
  parameter int unsigned PF_VECTOR = 'h33
) (
  input logic             clk,
  input logic             por_n,
  input logic             rst_n,
  input logic             ctl_we,
  input logic             ctl_sel,
  input logic [CTL_W-1:0] ctl_wdata,
  input logic             irq_any_i,
  input logic             wake_i,
  input logic             pf_irq_o,
  input logic [VEC_W-1:0] pf_vec_o,
  input logic             por_flag_o,
  input logic             pf_flag_o,
  input logic             bgs_o,
  input logic             idle_o,
  input logic             stop_o,
  input logic             cpu_clk_en_o,
  input logic             periph_clk_en_o,
  input logic             bg_en_o
);
  a_r3_por_sw_clear_only: assert property (@(posedge clk) disable iff (!por_n)
    $fell(por_flag_o) |-> $past(ctl_we && (ctl_sel == SEL_FLAGS) && !ctl_wdata[F_POF]));

  a_r5_pf_sw_clear_only: assert property (@(posedge clk) disable iff (!por_n)
    $fell(pf_flag_o) |-> $past(ctl_we && (ctl_sel == SEL_FLAGS) && !ctl_wdata[F_PFF]));

  a_r7_vector_on_irq: assert property (@(posedge clk) disable iff (!por_n)
    pf_irq_o |-> (pf_vec_o == VEC_W'(PF_VECTOR)));

  a_r8_stop_gates_all: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    stop_o |-> (!cpu_clk_en_o && !periph_clk_en_o && !idle_o));

  a_r9_idle_exit: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (idle_o && (pf_irq_o || irq_any_i)) |=> !idle_o);

  a_r10_stop_holds: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (stop_o && !wake_i) |=> stop_o);

  a_r11_bandgap_off: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (stop_o && !bgs_o) |-> (!bg_en_o && !pf_irq_o));

  a_r11_no_detect: assert property (@(posedge clk) disable iff (!por_n)
    (stop_o && !bgs_o && !pf_flag_o && !(ctl_we && (ctl_sel == SEL_FLAGS))) |=> !pf_flag_o);

  a_r12_bgs_frozen: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (stop_o || idle_o) |=> $stable(bgs_o));
endmodule

bind pwr_mode_ctrl pwr_mode_chk #(.VEC_W(VEC_W), .PF_VECTOR(PF_VECTOR)) u_chk (
  .clk             (clk),
  .por_n           (por_n),
  .rst_n           (rst_n),
  .ctl_we          (ctl_we),
  .ctl_sel         (ctl_sel),
  .ctl_wdata       (ctl_wdata),
  .irq_any_i       (irq_any_i),
  .wake_i          (wake_i),
  .pf_irq_o        (pf_irq_o),
  .pf_vec_o        (pf_vec_o),
  .por_flag_o      (por_flag_o),
  .pf_flag_o       (pf_flag_o),
  .bgs_o           (bgs_o),
  .idle_o          (idle_o),
  .stop_o          (stop_o),
  .cpu_clk_en_o    (cpu_clk_en_o),
  .periph_clk_en_o (periph_clk_en_o),
  .bg_en_o         (bg_en_o)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b0, pf_cmp_i = 1'b0;
  logic       ctl_we = 1'b0, ctl_sel = 1'b0;
  logic [2:0] ctl_wdata = '0;
  logic       irq_any_i = 1'b0, wake_i = 1'b0;
  logic       pf_irq_o, por_flag_o, pf_flag_o, pf_ien_o, bgs_o;
  logic       idle_o, stop_o, cpu_clk_en_o, periph_clk_en_o, bg_en_o;
  logic [7:0] pf_vec_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .pf_cmp_i(pf_cmp_i),
    .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
    .irq_any_i(irq_any_i), .wake_i(wake_i),
    .pf_irq_o(pf_irq_o), .pf_vec_o(pf_vec_o), .por_flag_o(por_flag_o),
    .pf_flag_o(pf_flag_o), .pf_ien_o(pf_ien_o), .bgs_o(bgs_o),
    .idle_o(idle_o), .stop_o(stop_o), .cpu_clk_en_o(cpu_clk_en_o),
    .periph_clk_en_o(periph_clk_en_o), .bg_en_o(bg_en_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [2:0] d);
    @(negedge clk);
    ctl_we = 1'b1; ctl_sel = sel; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic t_reset_state;
    chk("R1", "por_flag", por_flag_o, 1);
    chk("R1", "pf_flag", pf_flag_o, 0);
    chk("R1", "ien", pf_ien_o, 0);
    chk("R1", "bgs", bgs_o, 0);
    chk("R1", "idle/stop", {idle_o, stop_o}, 0);
    chk("R1", "clk ens", {cpu_clk_en_o, periph_clk_en_o, bg_en_o}, 3'b111);
    chk("R1", "irq/vec", {pf_irq_o, pf_vec_o}, 0);
  endtask

  task automatic t_por_clear;
    wr(1'b0, 3'b100);
    chk("R3", "por kept on write 1", por_flag_o, 1);
    wr(1'b0, 3'b000);
    chk("R3", "por cleared", por_flag_o, 0);
  endtask

  task automatic t_pf_detect;
    @(negedge clk); pf_cmp_i = 1'b1;
    wait_n(2);
    chk("R4", "flag before 3rd edge", pf_flag_o, 0);
    wait_n(1);
    chk("R4", "flag on 3rd edge", pf_flag_o, 1);
    chk("R7", "irq masked", {pf_irq_o, pf_vec_o}, 0);
    wr(1'b0, 3'b011);
    chk("R7", "irq enabled", pf_irq_o, 1);
    chk("R7", "vector", pf_vec_o, 'h33);
    wr(1'b0, 3'b001);
    wait_n(5);
    chk("R4", "one set per rise", pf_flag_o, 0);
    chk("R7", "irq low after clear", pf_irq_o, 0);
    pf_cmp_i = 1'b0;
    wait_n(3);
  endtask

  task automatic t_race;
    @(negedge clk); pf_cmp_i = 1'b1;
    wait_n(2);
    ctl_we = 1'b1; ctl_sel = 1'b0; ctl_wdata = 3'b001;
    @(negedge clk); ctl_we = 1'b0;
    chk("R5", "hw set beats sw clear", pf_flag_o, 1);
    pf_cmp_i = 1'b0;
    wait_n(4);
    chk("R5", "no hw clear", pf_flag_o, 1);
    wr(1'b0, 3'b001);
    chk("R5", "sw clear", pf_flag_o, 0);
  endtask

  task automatic t_force;
    wr(1'b0, 3'b011);
    chk("R6", "forced flag", pf_flag_o, 1);
    chk("R6", "forced irq", pf_irq_o, 1);
    wr(1'b0, 3'b010);
    chk("R7", "forced, ien 0", {pf_flag_o, pf_irq_o}, 2'b10);
    wr(1'b0, 3'b000);
  endtask

  task automatic t_idle;
    wr(1'b0, 3'b001);
    wr(1'b1, 3'b001);
    chk("R8", "idle entered", {idle_o, stop_o, cpu_clk_en_o, periph_clk_en_o}, 4'b1001);
    pulse(irq_any_i);
    chk("R9", "idle exit other irq", {idle_o, cpu_clk_en_o}, 2'b01);
    wr(1'b1, 3'b001);
    wr(1'b0, 3'b011);
    chk("R9", "still idle at irq", idle_o, 1);
    @(negedge clk);
    chk("R9", "idle exit pf irq", {idle_o, cpu_clk_en_o}, 2'b01);
    wr(1'b0, 3'b000);
  endtask

  task automatic t_stop;
    wr(1'b1, 3'b011);
    chk("R8", "stop priority", {idle_o, stop_o, cpu_clk_en_o, periph_clk_en_o}, 4'b0100);
    pulse(irq_any_i);
    chk("R10", "irq no exit", stop_o, 1);
    wr(1'b1, 3'b101);
    chk("R12", "mode write ignored", {stop_o, idle_o, bgs_o}, 3'b100);
    pulse(wake_i);
    chk("R10", "wake exit", {stop_o, cpu_clk_en_o, periph_clk_en_o}, 3'b011);
  endtask

  task automatic t_bgs;
    wr(1'b1, 3'b010);
    chk("R11", "bandgap off", bg_en_o, 0);
    pf_cmp_i = 1'b1;
    wait_n(5);
    chk("R11", "detect masked", pf_flag_o, 0);
    pulse(wake_i);
    pf_cmp_i = 1'b0;
    wait_n(3);
    wr(1'b1, 3'b110);
    chk("R11", "bandgap kept", {stop_o, bg_en_o}, 2'b11);
    pf_cmp_i = 1'b1;
    wait_n(3);
    chk("R11", "detect in stop", {pf_flag_o, stop_o}, 2'b11);
    pulse(wake_i);
    pf_cmp_i = 1'b0;
    chk("R11", "bgs persists", bgs_o, 1);
    wait_n(3);
  endtask

  task automatic t_warm;
    wr(1'b0, 3'b011);
    wr(1'b1, 3'b110);
    @(negedge clk); rst_n = 1'b0;
    wait_n(2); rst_n = 1'b1;
    chk("R2", "flags kept", {por_flag_o, pf_flag_o}, 2'b01);
    chk("R2", "ien/bgs cleared", {pf_ien_o, bgs_o}, 0);
    chk("R2", "run mode", {stop_o, idle_o, cpu_clk_en_o}, 3'b001);
    @(negedge clk); por_n = 1'b0;
    wait_n(2); por_n = 1'b1;
    chk("R1", "power-up again", {por_flag_o, pf_flag_o}, 2'b10);
  endtask

  initial begin
    wait_n(3);
    por_n = 1'b1; rst_n = 1'b1;
    t_reset_state();
    t_por_clear();
    t_pf_detect();
    t_race();
    t_force();
    t_idle();
    t_stop();
    t_bgs();
    t_warm();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule